// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flags

This block is a purely combinational two's-complement arithmetic unit for a datapath of `WIDTH` bits (16 by default). It performs four operations: plain add, add with the stored carry, plain subtract, and subtract with the stored borrow. A single ripple adder serves all four. For the subtract operations the second operand and the low carry-in are inverted, and the adder's carry-out is inverted on the way to the carry flag.

The carry flag therefore has two meanings. After an add it means unsigned overflow. After a subtract it means a borrow, or unsigned underflow. Besides the sum or difference, the unit produces four flags:

- negative: the top bit of the result.
- zero: the result is all zeros.
- carry/borrow: as described above.
- signed overflow: the carry into the top bit differs from the carry out of it.

A surrounding core stores the flags. It feeds the stored carry flag back in, so that operations can be chained across several words.

Top module: `asu_addsub`

## Requirements
- R1: `op_i` selects the operation: 2'b00 gives a+b, 2'b01 gives a+b+carry_flag_i, 2'b10 gives a-b, and 2'b11 gives a-b-carry_flag_i. `result_o` is the selected value modulo 2^WIDTH.
- R2: For 2'b00 and 2'b01, `carry_o` is 1 exactly when the true unsigned sum reaches 2^WIDTH.
- R3: For 2'b10 and 2'b11, `carry_o` is a borrow: it is 1 exactly when a < b + (carry_flag_i for 2'b11, else 0).
- R4: Subtracting zero with no borrow in never sets `carry_o`, and the result equals a. For example, at width 4, 0101-0000 gives result 0101 and carry 0.
- R5: `neg_o` equals result bit WIDTH-1. `zero_o` is 1 exactly when every result bit is 0.
- R6: `ovf_o` is 1 exactly when the signed result of the selected operation, including any carry or borrow in, lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1].
- R7: `ovf_o` agrees with the sign rule. For an add, the operands share a sign bit and the result's sign bit differs from it. For a subtract, the operands' sign bits differ and the result's sign bit equals b's sign bit.
- R8: The width-specific corners hold. At width 4: 0100+0100 gives V=1, C=0, and 1000+1000 gives C=1. At width 2: 00-01 gives C=1, V=0, and 10-01 gives C=0, V=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand (minuend on subtract) |
| b_i | input | WIDTH | Second operand (subtrahend on subtract) |
| op_i | input | 2 | Operation select, encoded as in R1 |
| carry_flag_i | input | 1 | Stored carry/borrow flag, used by the two chained operations |
| result_o | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry on add, borrow on subtract |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
The hardest cases to reach are the boundary patterns: a zero subtrahend, where the inverted operand plus one must carry through every bit, and operands that are zero or only the top bit set combined with a carry or borrow in. Random stimulus at full width almost never produces these. The bench therefore instantiates the unit at widths 2 and 4 and sweeps every operand pair under every operation and both stored-flag values, so each of those corners is applied directly. A random run at width 16 then confirms that the same behaviour holds at the default width.

// File: rtl/asu_pkg.sv
// Package: shared operation encoding for the add/subtract unit.
// Assumes op[1] marks subtraction and op[0] marks use of the stored flag.
package asu_pkg;
    typedef enum logic [1:0] {
        ASU_ADD = 2'b00,
        ASU_ADC = 2'b01,
        ASU_SUB = 2'b10,
        ASU_SBC = 2'b11
    } asu_op_e;
endpackage

// File: rtl/asu_operand_prep.sv
// Operand conditioning: inverts b and chooses the low carry-in so that a
// single adder computes all four operations.
// Assumes the stored flag holds carry after an add and borrow after a subtract.
module asu_operand_prep
    import asu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] b_i,
    input  asu_op_e          op_i,
    input  logic             flag_i,
    output logic [WIDTH-1:0] b_eff_o,
    output logic             cin_o,
    output logic             is_sub_o
);
    logic use_flag;

    // Decode the operation into subtract and chained-flag controls.
    always_comb begin
        is_sub_o = (op_i == ASU_SUB) || (op_i == ASU_SBC);
        use_flag = (op_i == ASU_ADC) || (op_i == ASU_SBC);
    end

    // Invert b on subtract; carry-in is the flag (add) or no-borrow (subtract).
    always_comb begin
        b_eff_o = is_sub_o ? ~b_i : b_i;
        if (use_flag)
            cin_o = is_sub_o ? ~flag_i : flag_i;
        else
            cin_o = is_sub_o;
    end
endmodule

// File: rtl/asu_ripple_adder.sv
// Ripple-carry adder built from one full-adder cell per bit.
// Exposes the carry into the top bit as well as the carry out of it.
// Assumes WIDTH >= 2.
module asu_ripple_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             c_top_in_o,
    output logic             c_out_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] chain;

    assign chain[0] = cin_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic prop;
        // Full-adder cell for bit i.
        always_comb begin
            prop          = x_i[i] ^ y_i[i];
            sum_o[i]      = prop ^ chain[i];
            chain[i+1]    = (x_i[i] & y_i[i]) | (prop & chain[i]);
        end
    end

    assign c_top_in_o = chain[MSB];
    assign c_out_o    = chain[WIDTH];
endmodule

// File: rtl/asu_flag_gen.sv
// Flag generation from the adder outputs.
// Assumes the raw carry-out came from an adder fed with inverted b on subtract.
module asu_flag_gen #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] sum_i,
    input  logic             c_top_in_i,
    input  logic             c_out_i,
    input  logic             is_sub_i,
    output logic             neg_o,
    output logic             zero_o,
    output logic             carry_o,
    output logic             ovf_o
);
    // Compute N, Z, C (borrow-corrected) and V (top-bit carry disagreement).
    always_comb begin
        neg_o   = sum_i[WIDTH-1];
        zero_o  = ~|sum_i;
        carry_o = c_out_i ^ is_sub_i;
        ovf_o   = c_top_in_i ^ c_out_i;
    end
endmodule

// File: rtl/asu_addsub.sv
// Top of the add/subtract unit: operand prep, one adder, flag generation.
// Purely combinational; the stored flag is supplied by the surrounding core.
module asu_addsub
    import asu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       op_i,
    input  logic             carry_flag_i,
    output logic [WIDTH-1:0] result_o,
    output logic             neg_o,
    output logic             zero_o,
    output logic             carry_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    asu_op_e          op;
    logic [WIDTH-1:0] b_eff;
    logic             cin;
    logic             is_sub;
    logic             c_top_in;
    logic             c_out;

    assign op = asu_op_e'(op_i);

    asu_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .b_i      (b_i),
        .op_i     (op),
        .flag_i   (carry_flag_i),
        .b_eff_o  (b_eff),
        .cin_o    (cin),
        .is_sub_o (is_sub)
    );

    asu_ripple_adder #(.WIDTH(WIDTH)) u_add (
        .x_i        (a_i),
        .y_i        (b_eff),
        .cin_i      (cin),
        .sum_o      (result_o),
        .c_top_in_o (c_top_in),
        .c_out_o    (c_out)
    );

    asu_flag_gen #(.WIDTH(WIDTH)) u_flags (
        .sum_i      (result_o),
        .c_top_in_i (c_top_in),
        .c_out_i    (c_out),
        .is_sub_i   (is_sub),
        .neg_o      (neg_o),
        .zero_o     (zero_o),
        .carry_o    (carry_o),
        .ovf_o      (ovf_o)
    );

    // Checks of the adder and flag outputs against wide arithmetic.
    logic [WIDTH:0] chk_sum;
    logic [WIDTH:0] chk_diff;
    logic           chk_flag_used;

    // Reference sum/difference in one extra bit, plus checks on outputs.
    always_comb begin
        chk_flag_used = op_i[0] & carry_flag_i;
        chk_sum  = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, chk_flag_used};
        chk_diff = {1'b0, a_i} - {1'b0, b_i} - {{WIDTH{1'b0}}, chk_flag_used};
        if (!op_i[1]) begin
            assert_add_carry_R2: assert ({carry_o, result_o} == chk_sum)
                else $error("R2 add carry/result mismatch");
            assert_ovf_sign_add_R7: assert (ovf_o ==
                ((a_i[MSB] == b_i[MSB]) && (result_o[MSB] != a_i[MSB])))
                else $error("R7 add overflow disagrees with sign rule");
        end else begin
            assert_sub_borrow_R3: assert ({carry_o, result_o} == chk_diff)
                else $error("R3 subtract borrow/result mismatch");
            assert_ovf_sign_sub_R7: assert (ovf_o ==
                ((a_i[MSB] != b_i[MSB]) && (result_o[MSB] == b_i[MSB])))
                else $error("R7 subtract overflow disagrees with sign rule");
            if (b_i == '0 && !chk_flag_used) begin
                assert_zero_subtrahend_R4: assert (!carry_o && result_o == a_i)
                    else $error("R4 zero subtrahend produced a borrow");
            end
        end
        assert_zero_flag_R5: assert (zero_o == ($countones(result_o) == 0))
            else $error("R5 zero flag mismatch");
    end
endmodule

// File: tb/asu_addsub_test.sv
// Bench: exhaustive sweeps at widths 2 and 4, random run at width 16,
// all against arithmetic computed here in integers.
module asu_addsub_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    logic [15:0] a16 = '0, b16 = '0;
    logic [3:0]  a4  = '0, b4  = '0;
    logic [1:0]  a2  = '0, b2  = '0;
    logic [1:0]  op16 = '0, op4 = '0, op2 = '0;
    logic        f16 = 1'b0, f4 = 1'b0, f2 = 1'b0;
    logic [15:0] r16;
    logic [3:0]  r4;
    logic [1:0]  r2;
    logic        n16, z16, c16, v16, n4, z4, c4, v4, n2, z2, c2, v2;

    asu_addsub #(.WIDTH(16)) uut (
        .a_i(a16), .b_i(b16), .op_i(op16), .carry_flag_i(f16),
        .result_o(r16), .neg_o(n16), .zero_o(z16), .carry_o(c16), .ovf_o(v16));
    asu_addsub #(.WIDTH(4)) uut4 (
        .a_i(a4), .b_i(b4), .op_i(op4), .carry_flag_i(f4),
        .result_o(r4), .neg_o(n4), .zero_o(z4), .carry_o(c4), .ovf_o(v4));
    asu_addsub #(.WIDTH(2)) uut2 (
        .a_i(a2), .b_i(b2), .op_i(op2), .carry_flag_i(f2),
        .result_o(r2), .neg_o(n2), .zero_o(z2), .carry_o(c2), .ovf_o(v2));

    task automatic cmp(string req, longint act, longint exp, string what);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference model for one operation at width w, compared to outputs.
    task automatic check(int w, longint a, longint b, int op, int f,
                         longint r, int n, int z, int c, int v);
        longint mod  = longint'(1) << w;
        longint half = mod / 2;
        longint fin  = (op % 2 == 1) ? f : 0;
        longint ua, sa, sb, sres, er;
        int ec, ev, en, ez, sign_rule;
        if (op < 2) begin
            ua = a + b + fin;
            ec = (ua >= mod) ? 1 : 0;
        end else begin
            ua = a - b - fin;
            ec = (ua < 0) ? 1 : 0;
        end
        er = ((ua % mod) + mod) % mod;
        sa = (a >= half) ? a - mod : a;
        sb = (b >= half) ? b - mod : b;
        sres = (op < 2) ? sa + sb + fin : sa - sb - fin;
        ev = (sres < -half || sres >= half) ? 1 : 0;
        en = (er >= half) ? 1 : 0;
        ez = (er == 0) ? 1 : 0;
        if (op < 2)
            sign_rule = ((a >= half) == (b >= half)) && ((er >= half) != (a >= half));
        else
            sign_rule = ((a >= half) != (b >= half)) && ((er >= half) == (b >= half));
        cmp("R1", r, er, "result");
        cmp(op < 2 ? "R2" : "R3", c, ec, "carry");
        cmp("R5", n, en, "neg");
        cmp("R5", z, ez, "zero");
        cmp("R6", v, ev, "ovf");
        cmp("R7", v, sign_rule, "ovf sign rule");
        if (op >= 2 && b == 0 && fin == 0) begin
            cmp("R4", c, 0, "zero subtrahend borrow");
            cmp("R4", r, a, "zero subtrahend result");
        end
    endtask

    initial begin
        // Watchdog: a hung run counts as a failure and still reports.
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        // Width-2 exhaustive sweep (R8 corners included).
        for (int op = 0; op < 4; op++)
            for (int f = 0; f < 2; f++)
                for (int a = 0; a < 4; a++)
                    for (int b = 0; b < 4; b++) begin
                        @(posedge clk);
                        a2 = a[1:0]; b2 = b[1:0]; op2 = op[1:0]; f2 = f[0];
                        @(negedge clk);
                        check(2, a, b, op, f, r2, n2, z2, c2, v2);
                    end
        // R8: 00-01 gives C=1 V=0; 10-01 gives C=0 V=1.
        @(posedge clk); a2 = 2'b00; b2 = 2'b01; op2 = 2'b10; f2 = 1'b0;
        @(negedge clk); cmp("R8", c2, 1, "00-01 C"); cmp("R8", v2, 0, "00-01 V");
        @(posedge clk); a2 = 2'b10; b2 = 2'b01;
        @(negedge clk); cmp("R8", c2, 0, "10-01 C"); cmp("R8", v2, 1, "10-01 V");

        // Width-4 exhaustive sweep.
        for (int op = 0; op < 4; op++)
            for (int f = 0; f < 2; f++)
                for (int a = 0; a < 16; a++)
                    for (int b = 0; b < 16; b++) begin
                        @(posedge clk);
                        a4 = a[3:0]; b4 = b[3:0]; op4 = op[1:0]; f4 = f[0];
                        @(negedge clk);
                        check(4, a, b, op, f, r4, n4, z4, c4, v4);
                    end
        // R8: 0100+0100 gives V=1 C=0; 1000+1000 gives C=1. R4: 0101-0000.
        @(posedge clk); a4 = 4'b0100; b4 = 4'b0100; op4 = 2'b00; f4 = 1'b0;
        @(negedge clk); cmp("R8", v4, 1, "4+4 V"); cmp("R8", c4, 0, "4+4 C");
        @(posedge clk); a4 = 4'b1000; b4 = 4'b1000;
        @(negedge clk); cmp("R8", c4, 1, "8+8 C"); cmp("R5", z4, 1, "8+8 zero");
        @(posedge clk); a4 = 4'b0101; b4 = 4'b0000; op4 = 2'b10;
        @(negedge clk); cmp("R4", c4, 0, "5-0 C"); cmp("R4", r4, 5, "5-0 result");

        // Width-16 random run over every operation and stored flag value.
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk);
            a16 = 16'($urandom); b16 = 16'($urandom);
            if (i % 8 == 0) b16 = '0;
            if (i % 16 == 4) a16 = 16'h8000;
            op16 = 2'(i % 4); f16 = 1'((i / 4) % 2);
            @(negedge clk);
            check(16, longint'(a16), longint'(b16), i % 4, (i / 4) % 2,
                  longint'(r16), n16, z16, c16, v16);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule